// File: doc/BRIEF.md
# Lockable Fully Associative TLB

This block is a small translation cache for 32-bit virtual addresses. It holds a parameterised number of entries (32 by default). Each entry carries a virtual tag, a physical page number, a valid flag, a preserve flag and a page-size code. Any entry may map a 4 KiB, 64 KiB, 1 MiB or 16 MiB page, so the tag comparison and the address merge depend on each entry's own size code. A lookup presents a virtual address for one cycle. One cycle later the block reports exactly one of three outcomes: a hit with the translated physical address, a miss, or a multiple-match fault.

Software fills the table through a staging path. It first writes the tag fields and the physical page into staging registers. A load strobe then copies them into the entry named by the victim pointer. A refill strobe does the same copy and also advances the victim pointer, in the way a hardware walker would after a refill. Entries whose index is below a programmable base are never reached by that advance, so they stay locked in place. There are two flush commands. A global flush drops every entry that is not preserved. An entry flush drops whatever matches the staged tag, including preserved entries. The entry under the victim pointer can always be read back.

Top module: `locked_assoc_tlb`

## Requirements
- R1: After reset every entry is invalid, the base index and the victim index are 0, and no lookup result is flagged.
- R2: A load strobe copies the staged tag, preserve, valid, size and physical page into the entry at the victim index. The copy is visible on the read-back outputs in the next cycle, and the victim index does not change.
- R3: One cycle after a lookup request, a single matching valid entry gives hit=1. The physical address is built from the entry's page number above the page offset and from the request address within the offset. The offset is 12, 16, 20 or 24 bits for size codes 2, 1, 0 and 3 respectively (2 = 4 KiB, 1 = 64 KiB, 0 = 1 MiB, 3 = 16 MiB).
- R4: A lookup that matches no valid entry gives miss=1, hit=0 and a physical address of 0.
- R5: A lookup that matches two or more valid entries gives multi=1, hit=0 and miss=0.
- R6: A lock write sets the base index and the victim index. A refill strobe writes the staged entry at the victim index and then moves the victim index up by one.
- R7: A refill at the last entry index wraps the victim index back to the base index, never below it.
- R8: A global flush invalidates every valid entry whose preserve flag is 0 and leaves preserved entries usable.
- R9: An entry flush invalidates every entry that matches the staged virtual tag under that entry's own page-size mask, preserved or not, and leaves other entries untouched.
- R10: An entry whose valid flag is 0 never takes part in a lookup match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_we | input | 1 | Write the staging registers |
| stage_vtag | input | 20 | Staged virtual tag (VA bits 31:12) |
| stage_pres | input | 1 | Staged preserve flag |
| stage_valid | input | 1 | Staged valid flag |
| stage_size | input | 2 | Staged page-size code |
| stage_ppn | input | 20 | Staged physical page (PA bits 31:12) |
| load_stb | input | 1 | Copy staging into the entry at the victim index |
| refill_stb | input | 1 | Copy staging into the victim entry, then advance the victim index |
| lock_we | input | 1 | Write base and victim indices (wins over a same-cycle refill advance) |
| lock_base | input | IDX_W | New locked-region base index |
| lock_victim | input | IDX_W | New victim index |
| gflush_stb | input | 1 | Invalidate all non-preserved entries |
| eflush_stb | input | 1 | Invalidate entries that match the staged tag |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Exactly one entry matched |
| res_miss | output | 1 | No entry matched |
| res_multi | output | 1 | More than one entry matched |
| res_paddr | output | 32 | Translated physical address (0 unless hit) |
| cur_base | output | IDX_W | Current base index |
| cur_victim | output | IDX_W | Current victim index |
| rb_vtag | output | 20 | Read-back tag of the victim entry |
| rb_pres | output | 1 | Read-back preserve flag |
| rb_valid | output | 1 | Read-back valid flag |
| rb_size | output | 2 | Read-back size code |
| rb_ppn | output | 20 | Read-back physical page |

## Verification
A wrong internal state shows at the ports within one or two cycles. A corrupted entry or a badly decoded write select appears at once on the read-back outputs when the victim pointer names that entry, and on the next lookup result as a wrong address or a wrong outcome. A flush that hits the wrong entries shows as a hit where a miss was due, or the reverse, on the first lookup after the flush. A victim pointer that advances or wraps incorrectly is visible on `cur_victim` in the cycle after the refill.

// File: rtl/tlb_pkg.sv
// Package: shared types and page-size helpers for the lockable TLB.
// Assumes a 32-bit virtual and physical address space with 4 KiB granularity.
package tlb_pkg;

    localparam int VA_W  = 32;
    localparam int TAG_W = 20;   // VA/PA bits 31:12

    typedef enum logic [1:0] {
        PG_1M  = 2'd0,
        PG_64K = 2'd1,
        PG_4K  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic [TAG_W-1:0] vtag;
        logic             pres;
        logic             valid;
        logic [1:0]       size;
    } tag_t;

    // Tag bits that take part in comparison for a given page size.
    function automatic logic [TAG_W-1:0] tag_mask(input logic [1:0] sz);
        case (pg_size_e'(sz))
            PG_4K:   tag_mask = 20'hFFFFF;
            PG_64K:  tag_mask = 20'hFFFF0;
            PG_1M:   tag_mask = 20'hFFF00;
            default: tag_mask = 20'hFF000;
        endcase
    endfunction

    // Merge physical page with the virtual page offset for a given size.
    function automatic logic [VA_W-1:0] merge_pa(input logic [TAG_W-1:0] ppn,
                                                 input logic [1:0]       sz,
                                                 input logic [VA_W-1:0]  va);
        logic [VA_W-1:0] hi_mask;
        hi_mask  = {tag_mask(sz), 12'h000};
        merge_pa = ({ppn, 12'h000} & hi_mask) | (va & ~hi_mask);
    endfunction

endpackage

// File: rtl/tlb_entry.sv
// Module: one TLB slot (tag plus physical page).
// Compares its tag against the lookup address and the staged flush tag,
// each under its own page-size mask. A write beats a flush in the same cycle.
module tlb_entry
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  tag_t             wr_tag,
    input  logic [TAG_W-1:0] wr_ppn,
    input  logic             gflush,
    input  logic             eflush,
    input  logic [TAG_W-1:0] flush_vtag,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_match,
    output tag_t             tag_q,
    output logic [TAG_W-1:0] ppn_q
);

    logic [TAG_W-1:0] mask;
    logic             fl_match;

    // Purpose: per-entry comparison mask and match terms.
    always_comb begin
        mask     = tag_mask(tag_q.size);
        lk_match = tag_q.valid &&
                   ((lk_vaddr[VA_W-1:12] & mask) == (tag_q.vtag & mask));
        fl_match = tag_q.valid && ((flush_vtag & mask) == (tag_q.vtag & mask));
    end

    // Purpose: entry storage with write, flush and reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            ppn_q <= '0;
        end else if (wr) begin
            tag_q <= wr_tag;
            ppn_q <= wr_ppn;
        end else if ((gflush && !tag_q.pres) || (eflush && fl_match)) begin
            tag_q.valid <= 1'b0;
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (tag_q == $past(wr_tag)) && (ppn_q == $past(wr_ppn)));

    assert_gflush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gflush && !wr && !tag_q.pres) |=> !tag_q.valid);

    assert_gflush_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gflush && !eflush && !wr && tag_q.pres && tag_q.valid) |=> tag_q.valid);

    assert_eflush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eflush && !wr && fl_match) |=> !tag_q.valid);

    assert_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_q.valid |-> !lk_match);

endmodule

// File: rtl/tlb_victim.sv
// Module: base and victim index keeper.
// A lock write loads both indices. A refill advances the victim index by one
// and wraps from the last slot back to the base, so slots below base are
// never picked. The lock write takes priority over the advance.
module tlb_victim #(
    parameter int N_ENTRIES = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_we,
    input  logic [IDX_W-1:0] lock_base,
    input  logic [IDX_W-1:0] lock_victim,
    input  logic             refill,
    output logic [IDX_W-1:0] base_q,
    output logic [IDX_W-1:0] victim_q
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

    // Purpose: index registers with lock write and refill advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            victim_q <= '0;
        end else if (lock_we) begin
            base_q   <= lock_base;
            victim_q <= lock_victim;
        end else if (refill) begin
            victim_q <= (victim_q == LAST) ? base_q : victim_q + 1'b1;
        end
    end

    assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (refill && !lock_we && victim_q != LAST) |=> victim_q == $past(victim_q) + 1'b1);

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (refill && !lock_we && victim_q == LAST) |=> victim_q == $past(base_q));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!refill && !lock_we) |=> $stable(victim_q) && $stable(base_q));

endmodule

// File: rtl/tlb_resolve.sv
// Module: lookup outcome resolver.
// Counts matching slots, picks the translation of a lone match and registers
// the result one cycle after the request. Assumes match lines are already
// qualified by each slot's valid flag.
module tlb_resolve
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lk_valid,
    input  logic [VA_W-1:0]             lk_vaddr,
    input  logic [N_ENTRIES-1:0]        match,
    input  logic [N_ENTRIES-1:0][TAG_W-1:0] ppn,
    input  logic [N_ENTRIES-1:0][1:0]   size,
    output logic                        res_valid,
    output logic                        res_hit,
    output logic                        res_miss,
    output logic                        res_multi,
    output logic [VA_W-1:0]             res_paddr
);

    logic            any_m;
    logic            multi_m;
    logic [VA_W-1:0] pa_or;

    // Purpose: reduce match lines to an outcome and an OR-muxed address.
    always_comb begin
        pa_or   = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (match[i]) pa_or = pa_or | merge_pa(ppn[i], size[i], lk_vaddr);
        end
        any_m   = |match;
        multi_m = (match & (match - 1'b1)) != '0;
    end

    // Purpose: register the lookup outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_multi <= 1'b0;
            res_paddr <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && any_m && !multi_m;
            res_miss  <= lk_valid && !any_m;
            res_multi <= lk_valid && multi_m;
            res_paddr <= (lk_valid && any_m && !multi_m) ? pa_or : '0;
        end
    end

    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_hit, res_miss, res_multi}) == 1);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_hit || res_miss || res_multi));

    assert_miss_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> res_paddr == '0);

    assert_multi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $countones(match) > 1) |=> res_multi && !res_hit);

endmodule

// File: rtl/locked_assoc_tlb.sv
// Module: lockable fully associative TLB top.
// Holds staging registers, decodes the victim index into a write select,
// instantiates the slots and the resolver, and muxes the victim slot to the
// read-back outputs. Assumes at most one command strobe per cycle; a write
// to a slot wins over a flush of that slot.
module locked_assoc_tlb
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stage_we,
    input  logic [19:0]      stage_vtag,
    input  logic             stage_pres,
    input  logic             stage_valid,
    input  logic [1:0]       stage_size,
    input  logic [19:0]      stage_ppn,
    input  logic             load_stb,
    input  logic             refill_stb,
    input  logic             lock_we,
    input  logic [IDX_W-1:0] lock_base,
    input  logic [IDX_W-1:0] lock_victim,
    input  logic             gflush_stb,
    input  logic             eflush_stb,
    input  logic             lk_valid,
    input  logic [31:0]      lk_vaddr,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_multi,
    output logic [31:0]      res_paddr,
    output logic [IDX_W-1:0] cur_base,
    output logic [IDX_W-1:0] cur_victim,
    output logic [19:0]      rb_vtag,
    output logic             rb_pres,
    output logic             rb_valid,
    output logic [1:0]       rb_size,
    output logic [19:0]      rb_ppn
);

    tag_t                              stg_tag;
    logic [TAG_W-1:0]                  stg_ppn;
    logic [N_ENTRIES-1:0]              wr_sel;
    logic [N_ENTRIES-1:0]              match;
    tag_t [N_ENTRIES-1:0]              tags;
    logic [N_ENTRIES-1:0][TAG_W-1:0]   ppns;
    logic [N_ENTRIES-1:0][1:0]         sizes;
    logic                              do_write;

    assign do_write = load_stb || refill_stb;

    // Purpose: staging registers filled by software before a load or refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_tag <= '0;
            stg_ppn <= '0;
        end else if (stage_we) begin
            stg_tag <= '{vtag: stage_vtag, pres: stage_pres,
                         valid: stage_valid, size: stage_size};
            stg_ppn <= stage_ppn;
        end
    end

    tlb_victim #(.N_ENTRIES(N_ENTRIES)) victim_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_we     (lock_we),
        .lock_base   (lock_base),
        .lock_victim (lock_victim),
        .refill      (refill_stb),
        .base_q      (cur_base),
        .victim_q    (cur_victim)
    );

    generate
        for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
            assign wr_sel[g] = do_write && (cur_victim == IDX_W'(g));
            assign sizes[g]  = tags[g].size;

            tlb_entry slot_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr         (wr_sel[g]),
                .wr_tag     (stg_tag),
                .wr_ppn     (stg_ppn),
                .gflush     (gflush_stb),
                .eflush     (eflush_stb),
                .flush_vtag (stg_tag.vtag),
                .lk_vaddr   (lk_vaddr),
                .lk_match   (match[g]),
                .tag_q      (tags[g]),
                .ppn_q      (ppns[g])
            );
        end
    endgenerate

    tlb_resolve #(.N_ENTRIES(N_ENTRIES)) resolve_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_vaddr  (lk_vaddr),
        .match     (match),
        .ppn       (ppns),
        .size      (sizes),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_miss  (res_miss),
        .res_multi (res_multi),
        .res_paddr (res_paddr)
    );

    // Purpose: read-back of the slot under the victim index.
    always_comb begin
        rb_vtag  = tags[cur_victim].vtag;
        rb_pres  = tags[cur_victim].pres;
        rb_valid = tags[cur_victim].valid;
        rb_size  = tags[cur_victim].size;
        rb_ppn   = ppns[cur_victim];
    end

    assert_onewrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    assert_victim_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && !lock_we && !refill_stb) |=> rb_vtag == $past(stg_tag.vtag));

endmodule

// File: tb/locked_assoc_tlb_tb.sv
// Bench: vector table of lookups, then directed tests for reset, read-back,
// refill advance and wrap, and both flush kinds.
module locked_assoc_tlb_tb_top;

    localparam int N     = 32;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stage_we = 0, stage_pres = 0, stage_valid = 0;
    logic [19:0]      stage_vtag = '0, stage_ppn = '0;
    logic [1:0]       stage_size = '0;
    logic             load_stb = 0, refill_stb = 0, lock_we = 0;
    logic [IDX_W-1:0] lock_base = '0, lock_victim = '0;
    logic             gflush_stb = 0, eflush_stb = 0, lk_valid = 0;
    logic [31:0]      lk_vaddr = '0;
    logic             res_valid, res_hit, res_miss, res_multi;
    logic [31:0]      res_paddr;
    logic [IDX_W-1:0] cur_base, cur_victim;
    logic [19:0]      rb_vtag, rb_ppn;
    logic             rb_pres, rb_valid;
    logic [1:0]       rb_size;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    locked_assoc_tlb #(.N_ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .stage_we(stage_we), .stage_vtag(stage_vtag), .stage_pres(stage_pres),
        .stage_valid(stage_valid), .stage_size(stage_size), .stage_ppn(stage_ppn),
        .load_stb(load_stb), .refill_stb(refill_stb),
        .lock_we(lock_we), .lock_base(lock_base), .lock_victim(lock_victim),
        .gflush_stb(gflush_stb), .eflush_stb(eflush_stb),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_multi(res_multi), .res_paddr(res_paddr),
        .cur_base(cur_base), .cur_victim(cur_victim),
        .rb_vtag(rb_vtag), .rb_pres(rb_pres), .rb_valid(rb_valid),
        .rb_size(rb_size), .rb_ppn(rb_ppn)
    );

    // Lookup vectors: {vaddr, hit, miss, multi, paddr}
    localparam int NV = 9;
    localparam logic [66:0] VEC [NV] = '{
        {32'h1234_5678, 3'b100, 32'hABCD_E678},  // 4 KiB      R3
        {32'h4000_ABCD, 3'b100, 32'h5555_ABCD},  // 64 KiB     R3
        {32'h800F_1234, 3'b100, 32'h123F_1234},  // 1 MiB      R3
        {32'hC0AB_CDEF, 3'b100, 32'h3FAB_CDEF},  // 16 MiB     R3
        {32'h8001_0000, 3'b001, 32'h0000_0000},  // overlap    R5
        {32'h9000_0000, 3'b010, 32'h0000_0000},  // invalid    R10
        {32'h0000_1000, 3'b010, 32'h0000_0000},  // empty      R4
        {32'h4001_0000, 3'b010, 32'h0000_0000},  // 64K edge   R4
        {32'h1234_6000, 3'b010, 32'h0000_0000}   // 4K edge    R4
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic stage(input logic [19:0] vt, input logic p, input logic v,
                         input logic [1:0] sz, input logic [19:0] pp);
        @(negedge clk);
        stage_we = 1; stage_vtag = vt; stage_pres = p; stage_valid = v;
        stage_size = sz; stage_ppn = pp;
        @(negedge clk);
        stage_we = 0;
    endtask

    task automatic set_lock(input int b, input int v);
        @(negedge clk);
        lock_we = 1; lock_base = IDX_W'(b); lock_victim = IDX_W'(v);
        @(negedge clk);
        lock_we = 0;
    endtask

    task automatic pulse_load();
        @(negedge clk); load_stb = 1; @(negedge clk); load_stb = 0;
    endtask

    task automatic pulse_refill();
        @(negedge clk); refill_stb = 1; @(negedge clk); refill_stb = 0;
    endtask

    task automatic pulse_gflush();
        @(negedge clk); gflush_stb = 1; @(negedge clk); gflush_stb = 0;
    endtask

    task automatic pulse_eflush();
        @(negedge clk); eflush_stb = 1; @(negedge clk); eflush_stb = 0;
    endtask

    task automatic lookup(input string req, input logic [31:0] va,
                          input logic [2:0] exp_flags, input logic [31:0] exp_pa);
        @(negedge clk);
        lk_valid = 1; lk_vaddr = va;
        @(negedge clk);
        lk_valid = 0;
        check(req, {28'h0, res_valid, res_hit, res_miss, res_multi, res_paddr},
                   {28'h0, 1'b1, exp_flags, exp_pa});
    endtask

    task automatic put(input int idx, input logic [19:0] vt, input logic p,
                       input logic v, input logic [1:0] sz, input logic [19:0] pp);
        set_lock(0, idx);
        stage(vt, p, v, sz, pp);
        pulse_load();
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 res_valid", res_valid, 0);
        check("R1 base", cur_base, 0);
        check("R1 victim", cur_victim, 0);
        check("R1 rb_valid", rb_valid, 0);
        lookup("R1 empty lookup", 32'h0000_0000, 3'b010, 32'h0);

        // Fill slots 0..5
        put(0, 20'h12345, 0, 1, 2'd2, 20'hABCDE);
        put(1, 20'h40000, 0, 1, 2'd1, 20'h55550);
        put(2, 20'h80000, 1, 1, 2'd0, 20'h12300);
        put(3, 20'hC0000, 0, 1, 2'd3, 20'h3F000);
        put(4, 20'h80010, 0, 1, 2'd2, 20'h77777);
        put(5, 20'h90000, 0, 0, 2'd2, 20'h99999);

        // R2 read-back of slot 5 and victim unchanged by load
        check("R2 rb_vtag", rb_vtag, 20'h90000);
        check("R2 rb_valid", rb_valid, 0);
        check("R2 rb_ppn", rb_ppn, 20'h99999);
        check("R2 victim held", cur_victim, 5);

        // Vector table walk (R3 R4 R5 R10)
        for (int i = 0; i < NV; i++) begin
            lookup("R3/R4/R5/R10 vector", VEC[i][66:35], VEC[i][34:32], VEC[i][31:0]);
        end

        // R6 refill write and advance
        set_lock(28, 30);
        check("R6 base", cur_base, 28);
        check("R6 victim", cur_victim, 30);
        stage(20'hA0000, 0, 1, 2'd2, 20'h11111);
        pulse_refill();
        check("R6 advance", cur_victim, 31);
        stage(20'hB0000, 1, 1, 2'd2, 20'h22222);
        pulse_refill();
        // R7 wrap to base
        check("R7 wrap", cur_victim, 28);
        check("R7 slot at base empty", rb_valid, 0);
        lookup("R6 refilled 30", 32'hA000_0123, 3'b100, 32'h1111_1123);
        lookup("R7 refilled 31", 32'hB000_0FFF, 3'b100, 32'h2222_2FFF);

        // R8 global flush
        pulse_gflush();
        lookup("R8 unpreserved 4K gone", 32'h1234_5678, 3'b010, 32'h0);
        lookup("R8 unpreserved 16M gone", 32'hC0AB_CDEF, 3'b010, 32'h0);
        lookup("R8 preserved 1M kept", 32'h800F_1234, 3'b100, 32'h123F_1234);
        lookup("R8 overlap now single", 32'h8001_0000, 3'b100, 32'h1231_0000);
        lookup("R8 preserved 31 kept", 32'hB000_0004, 3'b100, 32'h2222_2004);
        lookup("R8 unpreserved 30 gone", 32'hA000_0123, 3'b010, 32'h0);

        // R9 entry flush ignores preserve
        stage(20'h80000, 0, 0, 2'd2, 20'h00000);
        pulse_eflush();
        lookup("R9 preserved 1M flushed", 32'h800F_1234, 3'b010, 32'h0);
        lookup("R9 other kept", 32'hB000_0004, 3'b100, 32'h2222_2004);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule